// File: doc/BRIEF.md
# Block-Cipher Coprocessor Command Sequencer

This block is the control front end of a 128-bit block-cipher coprocessor. A CPU writes command words into a control port. Each word can ask for a key load, an IV/nonce load or a block start, and it can carry a chaining-mode code and two clear bits. Data moves one 32-bit word at a time. Words enter through an input register port and leave through an output register port. A one-cycle trigger fires on each side, one for the input DMA channel and one for the output DMA channel. The cipher rounds and the chaining datapath sit outside this block. They see the key, the IV, the mode and a 128-bit block, and they answer through a level request and a one-cycle done pulse.

The block enforces the order of operations. Each block needs its own start command, and that start pulses the input trigger. A start is refused until a full key and a full IV have been loaded. A new block is refused until all four result words of the previous block have been read. A key or IV load command aborts any block in flight. A deep low-power entry signal wipes the key and IV. When a block completes, a sticky flag is set, and that flag drives the interrupt output while the enable input is high.

Top module: `cipher_cmd_seq`

## Requirements
- R1: After reset, status, dout, in_trig, out_trig, irq and core_req are all 0, and key_out and iv_out are 0.
- R2: A control write with command 1 (bits [1:0]) clears key-valid (status bit 1). The next four din writes fill key_out words 0..3, with word 0 in bits [31:0]. After the fourth write, key-valid is set, and the key then stays until the next key command.
- R3: Command 2 does the same for iv_out and IV-valid (status bit 2). It also latches the mode field, control bits [4:2], into status bits [5:3] and mode_out.
- R4: Command 3 (start) is accepted when the block is idle and both valid bits are set. It sets busy (status bit 0), latches the mode, and raises in_trig for exactly the one cycle after the write.
- R5: A start that comes while key-valid or IV-valid is clear, or while the block is busy, changes nothing except the sticky error bit (status bit 6). A control write with bit 6 set clears the error bit, and a new error in the same cycle wins.
- R6: After the fourth data word, core_req stays high with a steady core_block until core_done arrives.
- R7: On core_done, core_result is captured and out_trig pulses for one cycle. dout then presents result words 0..3 in order, and each dout_rd advances to the next word. The block is idle after the fourth read. dout is 0 at all other times.
- R8: A key or IV command issued while a block is in progress drops core_req at once. A later core_done then sets no flag and raises no trigger.
- R9: A cycle with lowpwr_enter high clears key_out, iv_out and both valid bits, and returns the sequence to idle. It takes priority over any command or data in the same cycle.
- R10: The completion flag (status bit 7) is set by a captured completion. A control write with bit 5 set clears it, and a completion in the same cycle wins.
- R11: irq is high exactly while the completion flag and irq_en are both high.
- R12: A din_wr outside a load phase and a dout_rd outside the unload phase have no effect. A command in the same cycle as a din_wr wins, and the data word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lowpwr_enter | input | 1 | Deep low-power entry; wipes key and IV |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | [1:0] command, [4:2] mode, [5] clear flag, [6] clear error |
| irq_en | input | 1 | Interrupt enable |
| status | output | 8 | {flag, error, mode[2:0], iv valid, key valid, busy} |
| din_wr | input | 1 | Input data word strobe |
| din | input | 32 | Input data word |
| dout_rd | input | 1 | Output data word read strobe |
| dout | output | 32 | Current output data word |
| in_trig | output | 1 | Input DMA trigger pulse |
| out_trig | output | 1 | Output DMA trigger pulse |
| irq | output | 1 | Interrupt request |
| key_out | output | 128 | Key to the cipher core |
| iv_out | output | 128 | IV/nonce to the chaining datapath |
| mode_out | output | 3 | Chaining mode to the datapath |
| core_req | output | 1 | Block ready for the core, held until done |
| core_block | output | 128 | Assembled input block |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 128 | Core result, valid with core_done |

## Verification
The hardest cases to reach are the collisions at the core handshake. One is a completion that lands in the same cycle as a CPU flag clear. The other is a done pulse that arrives after a key or IV command has already aborted the block. The bench does not model the core as a free-running agent. It drives core_done and core_result itself, so it can hold a block in the waiting state for as long as it likes. It can then pair a done pulse with a clear write in the same cycle, or abort the block first and pulse done afterwards. A behavioural model tracks every output on every cycle, so it also catches a late or stray trigger.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;
  localparam int MODE_W = 3;
  localparam int CTL_W  = MODE_W + 4;
  localparam int STAT_W = MODE_W + 5;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_KEY = 2'd1,
    CMD_IV  = 2'd2,
    CMD_GO  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_KEY  = 3'd1,
    ST_IV   = 3'd2,
    ST_DATA = 3'd3,
    ST_WAIT = 3'd4,
    ST_OUT  = 3'd5
  } st_e;

  function automatic cmd_e ctl_cmd(input logic [CTL_W-1:0] w);
    return cmd_e'(w[1:0]);
  endfunction

  function automatic logic [MODE_W-1:0] ctl_mode(input logic [CTL_W-1:0] w);
    return w[2 +: MODE_W];
  endfunction

  function automatic logic ctl_clr_flag(input logic [CTL_W-1:0] w);
    return w[MODE_W + 2];
  endfunction

  function automatic logic ctl_clr_err(input logic [CTL_W-1:0] w);
    return w[MODE_W + 3];
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
    input logic busy, input logic kv, input logic ivv,
    input logic [MODE_W-1:0] mode, input logic err, input logic flag);
    return {flag, err, mode, ivv, kv, busy};
  endfunction
endpackage

// File: rtl/cseq_wordreg.sv
`timescale 1ns/1ps
module cseq_wordreg #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       wdata,
  input  logic                    ld,
  input  logic [WORDS*WORD_W-1:0] ld_data,
  output logic [WORDS*WORD_W-1:0] q
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           word_q <= '0;
      else if (clr)                         word_q <= '0;
      else if (ld)                          word_q <= ld_data[g*WORD_W +: WORD_W];
      else if (we && (idx == IDX_W'(g)))    word_q <= wdata;
    end
    assign q[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/cseq_fsm.sv
`timescale 1ns/1ps
module cseq_fsm
  import cseq_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lowpwr,
  input  logic             ctl_wr,
  input  cmd_e             cmd,
  input  logic             din_wr,
  input  logic             dout_rd,
  input  logic             core_done,
  input  logic             key_ok,
  input  logic             iv_ok,
  output st_e              state,
  output logic [IDX_W-1:0] idx,
  output logic             in_trig,
  output logic             out_trig,
  output logic             ev_key_we,
  output logic             ev_iv_we,
  output logic             ev_blk_we,
  output logic             ev_key_fill,
  output logic             ev_iv_fill,
  output logic             ev_key_drop,
  output logic             ev_iv_drop,
  output logic             ev_go_ok,
  output logic             ev_go_bad,
  output logic             ev_capture
);
  st_e              st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             in_trig_q, out_trig_q;
  logic             last;

  assign last = (idx_q == IDX_W'(WORDS - 1));

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    ev_key_we   = 1'b0;
    ev_iv_we    = 1'b0;
    ev_blk_we   = 1'b0;
    ev_key_fill = 1'b0;
    ev_iv_fill  = 1'b0;
    ev_key_drop = 1'b0;
    ev_iv_drop  = 1'b0;
    ev_go_ok    = 1'b0;
    ev_go_bad   = 1'b0;
    ev_capture  = 1'b0;
    if (lowpwr) begin
      st_d  = ST_IDLE;
      idx_d = '0;
    end else if (ctl_wr && (cmd != CMD_NOP)) begin
      case (cmd)
        CMD_KEY: begin
          st_d        = ST_KEY;
          idx_d       = '0;
          ev_key_drop = 1'b1;
        end
        CMD_IV: begin
          st_d       = ST_IV;
          idx_d      = '0;
          ev_iv_drop = 1'b1;
        end
        CMD_GO: begin
          if ((st_q == ST_IDLE) && key_ok && iv_ok) begin
            st_d     = ST_DATA;
            idx_d    = '0;
            ev_go_ok = 1'b1;
          end else begin
            ev_go_bad = 1'b1;
          end
        end
        default: ;
      endcase
    end else begin
      case (st_q)
        ST_KEY, ST_IV, ST_DATA: begin
          if (din_wr) begin
            ev_key_we = (st_q == ST_KEY);
            ev_iv_we  = (st_q == ST_IV);
            ev_blk_we = (st_q == ST_DATA);
            if (last) begin
              idx_d       = '0;
              ev_key_fill = (st_q == ST_KEY);
              ev_iv_fill  = (st_q == ST_IV);
              st_d        = (st_q == ST_DATA) ? ST_WAIT : ST_IDLE;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        ST_WAIT: begin
          if (core_done) begin
            ev_capture = 1'b1;
            st_d       = ST_OUT;
            idx_d      = '0;
          end
        end
        ST_OUT: begin
          if (dout_rd) begin
            if (last) begin
              st_d  = ST_IDLE;
              idx_d = '0;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        default: begin
          st_d  = ST_IDLE;
          idx_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      in_trig_q  <= 1'b0;
      out_trig_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      idx_q      <= idx_d;
      in_trig_q  <= ev_go_ok;
      out_trig_q <= ev_capture;
    end
  end

  assign state    = st_q;
  assign idx      = idx_q;
  assign in_trig  = in_trig_q;
  assign out_trig = out_trig_q;
endmodule

// File: rtl/cseq_status.sv
`timescale 1ns/1ps
module cseq_status
  import cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lowpwr,
  input  logic              key_drop,
  input  logic              key_fill,
  input  logic              iv_drop,
  input  logic              iv_fill,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              go_bad,
  input  logic              capture,
  input  logic              clr_flag,
  input  logic              clr_err,
  input  logic              irq_en,
  output logic              key_ok,
  output logic              iv_ok,
  output logic [MODE_W-1:0] mode,
  output logic              err,
  output logic              flag,
  output logic              irq
);
  logic              kv_q, iv_q, err_q, flag_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kv_q   <= 1'b0;
      iv_q   <= 1'b0;
      mode_q <= '0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (lowpwr || key_drop) kv_q <= 1'b0;
      else if (key_fill)      kv_q <= 1'b1;
      if (lowpwr || iv_drop)  iv_q <= 1'b0;
      else if (iv_fill)       iv_q <= 1'b1;
      if (mode_ld)            mode_q <= mode_in;
      err_q  <= go_bad  | (err_q  & ~clr_err);
      flag_q <= capture | (flag_q & ~clr_flag);
    end
  end

  assign key_ok = kv_q;
  assign iv_ok  = iv_q;
  assign mode   = mode_q;
  assign err    = err_q;
  assign flag   = flag_q;
  assign irq    = flag_q & irq_en;
endmodule

// File: rtl/cipher_cmd_seq.sv
`timescale 1ns/1ps
module cipher_cmd_seq
  import cseq_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BLOCK_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lowpwr_enter,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               irq_en,
  output logic [STAT_W-1:0]  status,
  input  logic               din_wr,
  input  logic [WORD_W-1:0]  din,
  input  logic               dout_rd,
  output logic [WORD_W-1:0]  dout,
  output logic               in_trig,
  output logic               out_trig,
  output logic               irq,
  output logic [BLOCK_W-1:0] key_out,
  output logic [BLOCK_W-1:0] iv_out,
  output logic [MODE_W-1:0]  mode_out,
  output logic               core_req,
  output logic [BLOCK_W-1:0] core_block,
  input  logic               core_done,
  input  logic [BLOCK_W-1:0] core_result
);
  localparam int WORDS = BLOCK_W / WORD_W;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  st_e              state;
  logic [IDX_W-1:0] idx;
  logic ev_key_we, ev_iv_we, ev_blk_we, ev_key_fill, ev_iv_fill;
  logic ev_key_drop, ev_iv_drop, ev_go_ok, ev_go_bad, ev_capture;
  logic key_ok, iv_ok, err, flag, busy;
  logic clr_flag, clr_err;
  logic [MODE_W-1:0]  mode;
  logic [BLOCK_W-1:0] res_q;

  assign clr_flag = ctl_wr && ctl_clr_flag(ctl_wdata);
  assign clr_err  = ctl_wr && ctl_clr_err(ctl_wdata);

  cseq_fsm #(.WORDS(WORDS), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr_enter),
    .ctl_wr(ctl_wr), .cmd(ctl_cmd(ctl_wdata)),
    .din_wr(din_wr), .dout_rd(dout_rd), .core_done(core_done),
    .key_ok(key_ok), .iv_ok(iv_ok),
    .state(state), .idx(idx), .in_trig(in_trig), .out_trig(out_trig),
    .ev_key_we(ev_key_we), .ev_iv_we(ev_iv_we), .ev_blk_we(ev_blk_we),
    .ev_key_fill(ev_key_fill), .ev_iv_fill(ev_iv_fill),
    .ev_key_drop(ev_key_drop), .ev_iv_drop(ev_iv_drop),
    .ev_go_ok(ev_go_ok), .ev_go_bad(ev_go_bad), .ev_capture(ev_capture)
  );

  cseq_status u_stat (
    .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr_enter),
    .key_drop(ev_key_drop), .key_fill(ev_key_fill),
    .iv_drop(ev_iv_drop), .iv_fill(ev_iv_fill),
    .mode_ld(ev_iv_drop | ev_go_ok), .mode_in(ctl_mode(ctl_wdata)),
    .go_bad(ev_go_bad), .capture(ev_capture),
    .clr_flag(clr_flag), .clr_err(clr_err), .irq_en(irq_en),
    .key_ok(key_ok), .iv_ok(iv_ok), .mode(mode), .err(err),
    .flag(flag), .irq(irq)
  );

  cseq_wordreg #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_key (
    .clk(clk), .rst_n(rst_n), .clr(lowpwr_enter), .we(ev_key_we),
    .idx(idx), .wdata(din), .ld(1'b0), .ld_data('0), .q(key_out)
  );

  cseq_wordreg #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_iv (
    .clk(clk), .rst_n(rst_n), .clr(lowpwr_enter), .we(ev_iv_we),
    .idx(idx), .wdata(din), .ld(1'b0), .ld_data('0), .q(iv_out)
  );

  cseq_wordreg #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .we(ev_blk_we),
    .idx(idx), .wdata(din), .ld(1'b0), .ld_data('0), .q(core_block)
  );

  cseq_wordreg #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .we(1'b0),
    .idx(idx), .wdata('0), .ld(ev_capture), .ld_data(core_result), .q(res_q)
  );

  assign busy     = (state != ST_IDLE);
  assign core_req = (state == ST_WAIT);
  assign mode_out = mode;
  assign status   = pack_status(busy, key_ok, iv_ok, mode, err, flag);
  assign dout     = (state == ST_OUT) ? res_q[idx*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/cseq_chk.sv
`timescale 1ns/1ps
module cseq_chk #(
  parameter int BLOCK_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lowpwr_enter,
  input logic               ctl_wr,
  input logic [1:0]         ctl_cmd,
  input logic               irq_en,
  input logic               key_ok,
  input logic               iv_ok,
  input logic               err,
  input logic               flag,
  input logic               in_trig,
  input logic               out_trig,
  input logic               irq,
  input logic [BLOCK_W-1:0] key_out,
  input logic [BLOCK_W-1:0] iv_out,
  input logic               core_req,
  input logic [BLOCK_W-1:0] core_block,
  input logic               core_done
);
  logic load_cmd;
  assign load_cmd = ctl_wr && ((ctl_cmd == 2'd1) || (ctl_cmd == 2'd2));

  assert_go_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_trig |=> !in_trig);

  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_cmd == 2'd3 && !key_ok && !lowpwr_enter) |=> (err && !in_trig));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !core_done && !lowpwr_enter && !load_cmd) |=> (core_req && $stable(core_block)));

  assert_trig_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_trig && out_trig));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && (load_cmd || lowpwr_enter)) |=> (!core_req && !out_trig));

  assert_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr_enter |=> (key_out == '0 && iv_out == '0 && !key_ok && !iv_ok));

  assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_done && !lowpwr_enter && !(ctl_wr && ctl_cmd != 2'd0)) |=> (flag && out_trig));

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq |-> irq_en) and ((flag && irq_en) |-> irq));
endmodule

bind cipher_cmd_seq cseq_chk #(.BLOCK_W(BLOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lowpwr_enter(lowpwr_enter),
  .ctl_wr(ctl_wr), .ctl_cmd(ctl_wdata[1:0]), .irq_en(irq_en),
  .key_ok(status[1]), .iv_ok(status[2]), .err(status[6]), .flag(status[7]),
  .in_trig(in_trig), .out_trig(out_trig), .irq(irq),
  .key_out(key_out), .iv_out(iv_out), .core_req(core_req),
  .core_block(core_block), .core_done(core_done)
);

// File: tb/tb_cipher_cmd_seq.sv
`timescale 1ns/1ps
module tb_cipher_cmd_seq;
  localparam int WW = 32;
  localparam int BW = 128;
  localparam int NW = BW / WW;

  logic clk = 0, rst_n = 0, lowpwr_enter = 0, ctl_wr = 0, irq_en = 0;
  logic [6:0] ctl_wdata = '0;
  logic din_wr = 0, dout_rd = 0, core_done = 0;
  logic [WW-1:0] din = '0;
  logic [BW-1:0] core_result = '0;
  logic [7:0] status;
  logic [WW-1:0] dout;
  logic in_trig, out_trig, irq, core_req;
  logic [BW-1:0] key_out, iv_out, core_block;
  logic [2:0] mode_out;

  cipher_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .lowpwr_enter(lowpwr_enter), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .irq_en(irq_en), .status(status), .din_wr(din_wr),
    .din(din), .dout_rd(dout_rd), .dout(dout), .in_trig(in_trig),
    .out_trig(out_trig), .irq(irq), .key_out(key_out), .iv_out(iv_out),
    .mode_out(mode_out), .core_req(core_req), .core_block(core_block),
    .core_done(core_done), .core_result(core_result)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle,1 key,2 iv,3 data,4 wait,5 unload
  int ms, mc;
  logic [WW-1:0] mk[NW], mi[NW], mb[NW], mo[NW];
  bit mkv, miv, merr, mflag, mit, mot;
  logic [2:0] mmode;

  function automatic logic [BW-1:0] join4(input logic [WW-1:0] a[NW]);
    logic [BW-1:0] r;
    for (int i = 0; i < NW; i++) r[i*WW +: WW] = a[i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mc = 0; mkv = 0; miv = 0; merr = 0; mflag = 0; mit = 0; mot = 0; mmode = 0;
      for (int i = 0; i < NW; i++) begin mk[i] = 0; mi[i] = 0; mb[i] = 0; mo[i] = 0; end
    end else begin
      mit = 0; mot = 0;
      if (ctl_wr && ctl_wdata[5]) mflag = 0;
      if (ctl_wr && ctl_wdata[6]) merr = 0;
      if (lowpwr_enter) begin
        for (int i = 0; i < NW; i++) begin mk[i] = 0; mi[i] = 0; end
        mkv = 0; miv = 0; ms = 0; mc = 0;
      end else if (ctl_wr && ctl_wdata[1:0] != 2'd0) begin
        if (ctl_wdata[1:0] == 2'd1) begin ms = 1; mc = 0; mkv = 0; end
        else if (ctl_wdata[1:0] == 2'd2) begin ms = 2; mc = 0; miv = 0; mmode = ctl_wdata[4:2]; end
        else if (ms == 0 && mkv && miv) begin ms = 3; mc = 0; mit = 1; mmode = ctl_wdata[4:2]; end
        else merr = 1;
      end else if (din_wr && ms >= 1 && ms <= 3) begin
        if (ms == 1) mk[mc] = din; else if (ms == 2) mi[mc] = din; else mb[mc] = din;
        mc++;
        if (mc == NW) begin
          mc = 0;
          if (ms == 1) begin mkv = 1; ms = 0; end
          else if (ms == 2) begin miv = 1; ms = 0; end
          else ms = 4;
        end
      end else if (ms == 4 && core_done) begin
        for (int i = 0; i < NW; i++) mo[i] = core_result[i*WW +: WW];
        ms = 5; mc = 0; mot = 1; mflag = 1;
      end else if (ms == 5 && dout_rd) begin
        mc++;
        if (mc == NW) begin mc = 0; ms = 0; end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(status[0] == (ms != 0), "R4 busy", BW'(status[0]), BW'(ms != 0));
      chk(status[1] == mkv, "R2 key valid", BW'(status[1]), BW'(mkv));
      chk(status[2] == miv, "R3 iv valid", BW'(status[2]), BW'(miv));
      chk(status[5:3] == mmode && mode_out == mmode, "R3 mode", BW'(status[5:3]), BW'(mmode));
      chk(status[6] == merr, "R5 error", BW'(status[6]), BW'(merr));
      chk(status[7] == mflag, "R10 flag", BW'(status[7]), BW'(mflag));
      chk(in_trig == mit, "R4 in_trig", BW'(in_trig), BW'(mit));
      chk(out_trig == mot, "R7 out_trig", BW'(out_trig), BW'(mot));
      chk(core_req == (ms == 4), "R6 core_req", BW'(core_req), BW'(ms == 4));
      chk(core_block == join4(mb), "R6 core_block", core_block, join4(mb));
      chk(dout == ((ms == 5) ? mo[mc] : '0), "R7 dout", BW'(dout), BW'((ms == 5) ? mo[mc] : '0));
      chk(irq == (mflag && irq_en), "R11 irq", BW'(irq), BW'(mflag && irq_en));
      chk(key_out == join4(mk), "R2 key", key_out, join4(mk));
      chk(iv_out == join4(mi), "R3 iv", iv_out, join4(mi));
    end
  end

  function automatic logic [6:0] cw(input logic [1:0] c, input logic [2:0] m, input bit cf, input bit ce);
    return {ce, cf, m, c};
  endfunction

  task automatic do_ctl(input logic [6:0] w);
    ctl_wr = 1; ctl_wdata = w; @(negedge clk); ctl_wr = 0; ctl_wdata = '0;
  endtask
  task automatic do_din(input logic [WW-1:0] d);
    din_wr = 1; din = d; @(negedge clk); din_wr = 0; din = '0;
  endtask
  task automatic do_rd();
    dout_rd = 1; @(negedge clk); dout_rd = 0;
  endtask
  task automatic do_done(output logic [BW-1:0] r);
    r = core_block ^ key_out ^ {NW{32'hA5C3_0F1E}};
    core_result = r; core_done = 1; @(negedge clk); core_done = 0;
  endtask
  task automatic load4(input logic [1:0] c, input logic [2:0] m, input logic [WW-1:0] base);
    do_ctl(cw(c, m, 0, 0));
    for (int i = 0; i < NW; i++) do_din(base + WW'(i));
  endtask
  task automatic push_block(input logic [WW-1:0] base);
    for (int i = 0; i < NW; i++) do_din(base ^ WW'(i * 7));
  endtask
  task automatic read_check(input logic [BW-1:0] r);
    for (int i = 0; i < NW; i++) begin
      chk(dout == r[i*WW +: WW], "R7 word order", BW'(dout), BW'(r[i*WW +: WW]));
      do_rd();
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] r;
    logic [BW-1:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 8'h00, "R1 status", BW'(status), 0);
    chk(dout == 0 && !in_trig && !out_trig && !irq && !core_req, "R1 outputs", BW'({dout, in_trig, out_trig, irq, core_req}), 0);
    chk(key_out == 0 && iv_out == 0, "R1 key iv", key_out | iv_out, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 start without key
    do_ctl(cw(2'd3, 3'd1, 0, 0));
    chk(status[6] && !in_trig, "R5 refused start", BW'(status[6]), 1);
    do_ctl(cw(2'd0, 3'd0, 0, 1));
    chk(!status[6], "R5 error clear", BW'(status[6]), 0);

    // R2 R3 loads
    load4(2'd1, 3'd0, 32'h1000_0000);
    chk(status[1] && key_out[31:0] == 32'h1000_0000, "R2 key loaded", key_out, 0);
    load4(2'd2, 3'd2, 32'h2000_0000);
    chk(status[2] && status[5:3] == 3'd2, "R3 iv and mode", BW'(status), 8'h16);

    // R4 R6 R7 R11 first block
    irq_en = 1;
    do_ctl(cw(2'd3, 3'd2, 0, 0));
    chk(in_trig && status[0], "R4 start trigger", BW'(in_trig), 1);
    push_block(32'hCAFE_0000);
    chk(core_req, "R6 request", BW'(core_req), 1);
    repeat (3) @(negedge clk);
    chk(core_req, "R6 request held", BW'(core_req), 1);
    do_done(r);
    chk(out_trig && status[7] && irq, "R7 R11 completion", BW'({out_trig, status[7], irq}), 3'b111);
    read_check(r);
    chk(!status[0], "R7 idle after reads", BW'(status[0]), 0);
    do_ctl(cw(2'd0, 3'd0, 1, 0));
    chk(!irq, "R11 irq drops", BW'(irq), 0);

    // second block, no reload; R5 busy refusals
    do_ctl(cw(2'd3, 3'd2, 0, 0));
    do_din(32'h1111_1111);
    do_ctl(cw(2'd3, 3'd2, 0, 0));
    chk(status[6], "R5 start while loading", BW'(status[6]), 1);
    do_din(32'h2222_2222); do_din(32'h3333_3333); do_din(32'h4444_4444);
    dout_rd = 1; @(negedge clk); dout_rd = 0;
    do_done(r);
    do_ctl(cw(2'd3, 3'd2, 0, 1));
    chk(status[6] && !in_trig, "R5 start while unloading", BW'(status[6]), 1);
    read_check(r);

    // R10 completion and clear same cycle
    do_ctl(cw(2'd0, 3'd0, 1, 1));
    do_ctl(cw(2'd3, 3'd5, 0, 0));
    push_block(32'h0BAD_F00D);
    r = core_block ^ key_out ^ {NW{32'hA5C3_0F1E}};
    core_result = r; core_done = 1; ctl_wr = 1; ctl_wdata = cw(2'd0, 3'd0, 1, 0);
    @(negedge clk);
    core_done = 0; ctl_wr = 0; ctl_wdata = '0;
    chk(status[7], "R10 set wins over clear", BW'(status[7]), 1);
    read_check(r);
    do_ctl(cw(2'd0, 3'd0, 1, 0));
    chk(!status[7], "R10 cleared", BW'(status[7]), 0);

    // R8 abort by IV command while waiting on the core
    do_ctl(cw(2'd3, 3'd1, 0, 0));
    push_block(32'h7777_0000);
    do_ctl(cw(2'd2, 3'd1, 0, 0));
    chk(!core_req && !status[2], "R8 abort drops request", BW'(core_req), 0);
    do_done(r);
    chk(!status[7] && !out_trig, "R8 late done ignored", BW'({status[7], out_trig}), 0);
    for (int i = 0; i < NW; i++) do_din(32'h3000_0000 + WW'(i));
    chk(status[2], "R3 iv reloaded", BW'(status[2]), 1);

    // R12 stray data and reads
    keep = key_out;
    do_din(32'hDEAD_BEEF);
    do_rd();
    chk(key_out == keep && iv_out[31:0] == 32'h3000_0000, "R12 stray din ignored", key_out, keep);
    chk(dout == 0 && !status[0], "R12 stray read ignored", BW'(dout), 0);
    do_ctl(cw(2'd1, 3'd0, 0, 0));
    do_din(32'hAAAA_0000);
    ctl_wr = 1; ctl_wdata = cw(2'd1, 3'd0, 0, 0); din_wr = 1; din = 32'hBBBB_0000;
    @(negedge clk);
    ctl_wr = 0; ctl_wdata = '0; din_wr = 0; din = '0;
    chk(key_out[63:32] == keep[63:32] && key_out[31:0] == 32'hAAAA_0000, "R12 command beats data", key_out, keep);
    for (int i = 0; i < NW; i++) do_din(32'hC000_0000 + WW'(i));
    chk(key_out == {32'hC000_0003, 32'hC000_0002, 32'hC000_0001, 32'hC000_0000} && status[1], "R2 key replaced", key_out, 0);

    // R9 low-power wipe with a start in the same cycle
    lowpwr_enter = 1; ctl_wr = 1; ctl_wdata = cw(2'd3, 3'd0, 0, 0);
    @(negedge clk);
    lowpwr_enter = 0; ctl_wr = 0; ctl_wdata = '0;
    chk(key_out == 0 && iv_out == 0 && !status[1] && !status[2] && !in_trig, "R9 wipe", key_out | iv_out, 0);
    do_ctl(cw(2'd3, 3'd0, 0, 0));
    chk(status[6], "R9 start refused after wipe", BW'(status[6]), 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule